// File: doc/BRIEF.md
# Edge-Interrupt GPIO Bank

This block is a bank of 32 general-purpose I/O lines, arranged as four 8-bit ports, reached through a small 32-bit register bus. Software sets each line's direction and output level, reads the pin state, and sets a per-line selection bit that the block only stores. Every input is brought into the clock domain through a two-flop synchronizer before any use.

Each line can raise an edge interrupt. A 2-bit field per line chooses the edges that count: falling, rising, both, or none. A detected edge latches a status bit. The single interrupt output is the OR of all status bits. Software clears status bits by writing ones, and the byte enables limit a clear to the ports that are selected. Byte and halfword writes change only the lanes they enable. Port A always sits in the lowest byte lane.

Top module: `gpio_bank`

## Requirements
- R1: After reset every register reads 0, `pinOe` and `pinOut` are 0 and `irq` is low. Every line therefore starts as an input with its interrupt disabled.
- R2: The direction word at byte offset 0x08 drives `pinOe`. A bit value of 1 makes the line an output. Bit k belongs to line k, and port A is bits 7:0.
- R3: A write to offset 0x0C sets `pinOut`. A read of 0x0C returns the synchronized `pinIn`. A pin change shows up in this read after the second rising clock edge that follows it.
- R4: The select word at offset 0x00 is stored and reads back unchanged. A write to it leaves `pinOut` and `pinOe` unchanged.
- R5: Interrupt configuration uses two bits per line. Offset 0x14 holds ports A (bits 15:0) and B (bits 31:16). Offset 0x18 holds ports C and D in the same layout. Line n of a port uses bits 2n+1:2n of its halfword. Code 1 selects the falling edge, code 2 the rising edge, code 3 both edges, and code 0 none.
- R6: A pin edge that matches the line's code sets that line's status bit at offset 0x10 on the third rising clock edge after the pin changes, and not before. `irq` is the OR of all status bits.
- R7: Writing 1 to a status bit clears it and writing 0 leaves it set. Byte lane k (port k) is affected only when byte enable k is set.
- R8: When a new edge and a clear hit the same status bit in the same cycle, the bit stays set.
- R9: `irq` stays high while any status bit remains set, including after a partial clear.
- R10: Offsets 0x04 and 0x1C read as 0, and writes to them change no register.
- R11: A write changes only the byte lanes whose enable bit is set. The other lanes keep their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 5 | Byte offset of the register word; bits 1:0 are ignored |
| busWe | input | 1 | Write strobe for one cycle |
| busBe | input | 4 | Byte enables; bit k enables bits 8k+7:8k |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for `busAddr`, combinational |
| pinIn | input | 32 | Asynchronous pin inputs |
| pinOut | output | 32 | Output levels |
| pinOe | output | 32 | Output enables |
| irq | output | 1 | Combined interrupt, high while any status bit is set |

## Verification
The bench builds the bank with its default parameters: four ports of eight lines and a two-stage synchronizer. With this build a single 32-bit word covers every line, so one clear can span all four ports. It also fixes the edge-to-status latency at exactly three clock edges, which lets the bench time a clear to land in the same cycle as a new edge. The configuration tests reach both configuration words, and port D is reached through the upper halfword of the second word, so the field layout is checked at both ends of the bank.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  parameter int PORT_W      = 8;
  parameter int NUM_PORTS   = 4;
  parameter int SYNC_STAGES = 2;
  parameter int ADDR_W      = 5;
  parameter int DATA_W      = 32;
  localparam int LINES      = PORT_W * NUM_PORTS;
  localparam int BE_W       = DATA_W / 8;
  localparam int CFG_W      = 2 * LINES;

  // word index = byte offset / 4
  typedef enum logic [2:0] {
    SEL_PINSEL = 3'd0,
    SEL_NONE1  = 3'd1,
    SEL_DIR    = 3'd2,
    SEL_DATA   = 3'd3,
    SEL_STAT   = 3'd4,
    SEL_CFGLO  = 3'd5,
    SEL_CFGHI  = 3'd6,
    SEL_NONE7  = 3'd7
  } regSel_e;

  typedef struct packed {
    logic            wrPinSel;
    logic            wrDir;
    logic            wrData;
    logic            wrClr;
    logic            wrCfgLo;
    logic            wrCfgHi;
    logic [BE_W-1:0] laneEn;
  } busStrobe_t;

  function automatic logic [DATA_W-1:0] laneMerge(
    input logic [DATA_W-1:0] oldVal,
    input logic [DATA_W-1:0] newVal,
    input logic [BE_W-1:0]   be);
    logic [DATA_W-1:0] res;
    for (int b = 0; b < BE_W; b++)
      res[b*8 +: 8] = be[b] ? newVal[b*8 +: 8] : oldVal[b*8 +: 8];
    return res;
  endfunction
endpackage

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
(
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [BE_W-1:0]   busBe,
  output busStrobe_t        stb,
  output regSel_e           rdSel
);
  assign rdSel = regSel_e'(busAddr[ADDR_W-1:2]);

  always_comb begin
    stb          = '0;
    stb.laneEn   = busBe;
    if (busWe) begin
      unique case (rdSel)
        SEL_PINSEL: stb.wrPinSel = 1'b1;
        SEL_DIR:    stb.wrDir    = 1'b1;
        SEL_DATA:   stb.wrData   = 1'b1;
        SEL_STAT:   stb.wrClr    = 1'b1;
        SEL_CFGLO:  stb.wrCfgLo  = 1'b1;
        SEL_CFGHI:  stb.wrCfgHi  = 1'b1;
        default:    ;
      endcase
    end
  end
endmodule

// File: rtl/gpio_bank_dp.sv
module gpio_bank_dp
  import gpio_bank_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  busStrobe_t        stb,
  input  regSel_e           rdSel,
  input  logic [DATA_W-1:0] wdata,
  input  logic [LINES-1:0]  pinIn,
  output logic [DATA_W-1:0] rdata,
  output logic [LINES-1:0]  pinOut,
  output logic [LINES-1:0]  pinOe,
  output logic              irq
);
  logic [LINES-1:0] pinSelQ, dirQ, dataQ, statQ, prevQ, hit, clrMask;
  logic [CFG_W-1:0] cfgQ;
  logic [SYNC_STAGES-1:0][LINES-1:0] syncChain;
  logic [LINES-1:0] pinSync;

  assign pinSync = syncChain[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rstN) syncChain <= '0;
    else       syncChain <= {syncChain[SYNC_STAGES-2:0], pinIn};
  end

  always_ff @(posedge clk) begin
    if (!rstN) prevQ <= '0;
    else       prevQ <= pinSync;
  end

  // edge match per line against its 2-bit code
  for (genvar n = 0; n < LINES; n++) begin : g_edge
    logic riseN, fallN;
    assign riseN  = pinSync[n] & ~prevQ[n];
    assign fallN  = ~pinSync[n] & prevQ[n];
    assign hit[n] = (cfgQ[2*n+1] & riseN) | (cfgQ[2*n] & fallN);
  end

  for (genvar b = 0; b < BE_W; b++) begin : g_clr
    assign clrMask[b*8 +: 8] = (stb.wrClr && stb.laneEn[b]) ? wdata[b*8 +: 8] : 8'h00;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pinSelQ <= '0;
      dirQ    <= '0;
      dataQ   <= '0;
      cfgQ    <= '0;
      statQ   <= '0;
    end else begin
      if (stb.wrPinSel) pinSelQ <= laneMerge(pinSelQ, wdata, stb.laneEn);
      if (stb.wrDir)    dirQ    <= laneMerge(dirQ, wdata, stb.laneEn);
      if (stb.wrData)   dataQ   <= laneMerge(dataQ, wdata, stb.laneEn);
      if (stb.wrCfgLo)  cfgQ[DATA_W-1:0]      <= laneMerge(cfgQ[DATA_W-1:0], wdata, stb.laneEn);
      if (stb.wrCfgHi)  cfgQ[CFG_W-1:DATA_W]  <= laneMerge(cfgQ[CFG_W-1:DATA_W], wdata, stb.laneEn);
      statQ <= (statQ & ~clrMask) | hit;
    end
  end

  always_comb begin
    unique case (rdSel)
      SEL_PINSEL: rdata = pinSelQ;
      SEL_DIR:    rdata = dirQ;
      SEL_DATA:   rdata = pinSync;
      SEL_STAT:   rdata = statQ;
      SEL_CFGLO:  rdata = cfgQ[DATA_W-1:0];
      SEL_CFGHI:  rdata = cfgQ[CFG_W-1:DATA_W];
      default:    rdata = '0;
    endcase
  end

  assign pinOut = dataQ;
  assign pinOe  = dirQ;
  assign irq    = |statQ;
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [BE_W-1:0]   busBe,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic [LINES-1:0]  pinIn,
  output logic [LINES-1:0]  pinOut,
  output logic [LINES-1:0]  pinOe,
  output logic              irq
);
  busStrobe_t stb;
  regSel_e    rdSel;

  gpio_bank_ctrl u_ctrl (
    .busAddr(busAddr), .busWe(busWe), .busBe(busBe),
    .stb(stb), .rdSel(rdSel)
  );

  gpio_bank_dp u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .rdSel(rdSel), .wdata(busWdata),
    .pinIn(pinIn), .rdata(busRdata), .pinOut(pinOut), .pinOe(pinOe), .irq(irq)
  );
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk
  import gpio_bank_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWe,
  input logic [BE_W-1:0]   busBe,
  input logic [DATA_W-1:0] busWdata,
  input logic [DATA_W-1:0] busRdata,
  input logic [LINES-1:0]  pinOut,
  input logic [LINES-1:0]  pinOe,
  input logic              irq
);
  logic [2:0] wordIdx;
  assign wordIdx = busAddr[ADDR_W-1:2];

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (!irq && pinOe == '0 && pinOut == '0));

  assert_oe_follows_dir_R2: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && wordIdx == 3'd2 && busBe == '1) |=> (pinOe == $past(busWdata)));

  assert_out_follows_data_R3: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && wordIdx == 3'd3 && busBe == '1) |=> (pinOut == $past(busWdata)));

  assert_pinsel_no_effect_R4: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && wordIdx == 3'd0) |=> ($stable(pinOut) && $stable(pinOe)));

  assert_irq_held_R9: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !(busWe && wordIdx == 3'd4)) |=> irq);

  assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (!rstN)
    (wordIdx == 3'd1 || wordIdx == 3'd7) |-> (busRdata == '0));
endmodule

bind gpio_bank gpio_bank_chk u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe), .busBe(busBe),
  .busWdata(busWdata), .busRdata(busRdata), .pinOut(pinOut), .pinOe(pinOe),
  .irq(irq)
);

// File: tb/gpio_bank_test.sv
module gpio_bank_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [4:0]  busAddr = '0;
  logic        busWe = 1'b0;
  logic [3:0]  busBe = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [31:0] pinIn = '0;
  logic [31:0] pinOut, pinOe;
  logic        irq;

  int nChecks = 0;
  int nFails  = 0;

  always #4 clk = ~clk;

  gpio_bank uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe), .busBe(busBe),
    .busWdata(busWdata), .busRdata(busRdata), .pinIn(pinIn),
    .pinOut(pinOut), .pinOe(pinOe), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [4:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busBe = be; busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0; busBe = '0;
  endtask

  task automatic busRead(input logic [4:0] a, output logic [31:0] d);
    busAddr = a;
    #1;
    d = busRdata;
  endtask

  task automatic waitEdges(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic testReset();
    logic [31:0] v;
    for (int w = 0; w < 8; w++) begin
      busRead(5'(w * 4), v);
      check("R1 register after reset", v, 32'h0);
    end
    check("R1 pinOe", pinOe, 32'h0);
    check("R1 pinOut", pinOut, 32'h0);
    check("R1 irq", {31'h0, irq}, 32'h0);
  endtask

  task automatic testDir();
    logic [31:0] v;
    busWrite(5'h08, 4'hF, 32'hA5C3_0F01);
    check("R2 pinOe full write", pinOe, 32'hA5C3_0F01);
    busWrite(5'h08, 4'h2, 32'hFFFF_FFFF);
    check("R11 dir single lane", pinOe, 32'hA5C3_FF01);
    busRead(5'h08, v);
    check("R2 dir readback", v, 32'hA5C3_FF01);
  endtask

  task automatic testData();
    logic [31:0] v;
    busWrite(5'h0C, 4'hF, 32'h1234_5678);
    check("R3 pinOut", pinOut, 32'h1234_5678);
    busWrite(5'h0C, 4'hC, 32'h9ABC_0000);
    check("R11 data halfword", pinOut, 32'h9ABC_5678);
    @(negedge clk);
    pinIn = 32'hCAFE_BABE;
    @(negedge clk);
    busRead(5'h0C, v);
    check("R3 read before sync done", v, 32'h0);
    @(negedge clk);
    busRead(5'h0C, v);
    check("R3 read after sync", v, 32'hCAFE_BABE);
    pinIn = '0;
    waitEdges(4);
  endtask

  task automatic testPinSel();
    logic [31:0] v;
    busWrite(5'h00, 4'hF, 32'hDEAD_BEEF);
    busRead(5'h00, v);
    check("R4 select readback", v, 32'hDEAD_BEEF);
    check("R4 pinOut untouched", pinOut, 32'h9ABC_5678);
    check("R4 pinOe untouched", pinOe, 32'hA5C3_FF01);
  endtask

  task automatic testEdges();
    logic [31:0] v;
    // lines 0..3: rise, fall, both, none
    busWrite(5'h14, 4'h3, 32'hFFFF_0036);
    busRead(5'h14, v);
    check("R5 cfg lo readback", v, 32'h0000_0036);
    // port D line 0 (line 24): both edges via upper halfword
    busWrite(5'h18, 4'hC, 32'h0003_0000);
    busRead(5'h18, v);
    check("R5 cfg hi readback", v, 32'h0003_0000);
    @(negedge clk);
    pinIn = 32'h0100_000F;
    waitEdges(2);
    busRead(5'h10, v);
    check("R6 status not yet set", v, 32'h0);
    @(negedge clk);
    busRead(5'h10, v);
    check("R5 rising edges", v, 32'h0100_0005);
    check("R6 irq raised", {31'h0, irq}, 32'h1);
    busWrite(5'h10, 4'hF, 32'h0000_0005);
    busRead(5'h10, v);
    check("R7 clear two bits", v, 32'h0100_0000);
    @(negedge clk);
    pinIn = 32'h0100_0000;
    waitEdges(3);
    busRead(5'h10, v);
    check("R5 falling edges", v, 32'h0100_0006);
  endtask

  task automatic testClear();
    logic [31:0] v;
    busWrite(5'h10, 4'h1, 32'hFFFF_FF02);
    busRead(5'h10, v);
    check("R7 lane gated clear", v, 32'h0100_0004);
    check("R9 irq after partial clear", {31'h0, irq}, 32'h1);
    busWrite(5'h10, 4'hF, 32'h0000_0000);
    busRead(5'h10, v);
    check("R7 zero write no effect", v, 32'h0100_0004);
    busWrite(5'h10, 4'hF, 32'h0100_0004);
    busRead(5'h10, v);
    check("R7 full clear", v, 32'h0);
    check("R9 irq dropped", {31'h0, irq}, 32'h0);
  endtask

  task automatic testSetWins();
    logic [31:0] v;
    @(negedge clk);
    pinIn[2] = 1'b1;
    waitEdges(3);
    busRead(5'h10, v);
    check("R8 first edge set", v, 32'h0000_0004);
    pinIn[2] = 1'b0;
    waitEdges(2);
    busAddr = 5'h10; busBe = 4'hF; busWdata = 32'h0000_0004; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0; busBe = '0;
    busRead(5'h10, v);
    check("R8 set beats clear", v, 32'h0000_0004);
    busWrite(5'h10, 4'hF, 32'h0000_0004);
    busRead(5'h10, v);
    check("R8 later clear", v, 32'h0);
  endtask

  task automatic testUnmapped();
    logic [31:0] v;
    busWrite(5'h04, 4'hF, 32'hFFFF_FFFF);
    busRead(5'h04, v);
    check("R10 offset 0x04", v, 32'h0);
    busWrite(5'h1C, 4'hF, 32'hFFFF_FFFF);
    busRead(5'h1C, v);
    check("R10 offset 0x1C", v, 32'h0);
    busRead(5'h08, v);
    check("R10 dir intact", v, 32'hA5C3_FF01);
    busRead(5'h00, v);
    check("R10 select intact", v, 32'hDEAD_BEEF);
    check("R10 pinOut intact", pinOut, 32'h9ABC_5678);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testDir();
    testData();
    testPinSel();
    testEdges();
    testClear();
    testSetWins();
    testUnmapped();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule